// File: doc/BRIEF.md
# Working Register File with Single-Level Shadow Save

This block holds the sixteen 16-bit working registers of a processor core and its 16-bit status register. Two combinational read ports serve operand fetch. A single write port updates one register per clock edge as a whole word or as its low byte only. The status register takes a full word from the external arithmetic unit whenever its write strobe is raised.

A small hidden shadow store supports fast context save. A save strobe copies registers 0 to 3 and five arithmetic flags into the shadow store. These flags are carry, zero, overflow, negative and digit carry. A restore strobe copies those values back. The shadow store is one level deep. It cannot be seen or changed through the ports, and it changes only on the save strobe. On reset, register 15, the stack pointer, takes 0x0800 and everything else clears.

Status bit layout, fixed by this block: bit 0 carry, bit 1 zero, bit 2 overflow, bit 3 negative, bit 4 repeat-active, bits 7:5 priority level, bit 8 digit carry, bit 9 loop-active, bits 15:10 general status.

Top module: `rf_core`

## Requirements
- R1: Both read ports return the addressed register combinationally. A write becomes visible on the read ports after the rising clock edge at which it was presented, and a cycle with `wr_en` low changes nothing.
- R2: A word write (`wr_byte` = 0) replaces all 16 bits of the addressed register.
- R3: A byte write (`wr_byte` = 1) replaces bits 7:0 of the addressed register and keeps bits 15:8.
- R4: Reset (synchronous, active high) loads register 15 with 0x0800 and clears the other registers, the status register and the shadow store. Register 15 can then be written like any other register.
- R5: When `st_wr_en` is high, the status register takes `st_wr_data` at the clock edge, using the bit layout given above.
- R6: `shadow_save` copies the current registers 0 to 3 and status bits 0, 1, 2, 3 and 8 (mask 0x010F) into the shadow store.
- R7: `shadow_restore` writes the shadow values back into registers 0 to 3 and status bits 0x010F. Every other status bit keeps its value, or takes `st_wr_data` if a status write occurs in the same cycle.
- R8: Writes to registers 0 to 3 and to status after a save do not alter the shadow store, and the shadow store never appears on a read port.
- R9: When a restore and a port write to register 0 to 3 occur in the same cycle, the restored value wins. A port write to register 4 or above in a restore cycle takes effect normally.
- R10: The shadow store holds one level, so a second save overwrites the first.
- R11: A save and a restore in the same cycle exchange the live and shadow values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| rd_addr_a | input | 4 | Read port A register index |
| rd_data_a | output | 16 | Read port A data |
| rd_addr_b | input | 4 | Read port B register index |
| rd_data_b | output | 16 | Read port B data |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write index |
| wr_byte | input | 1 | 1 = low byte only, 0 = whole word |
| wr_data | input | 16 | Register write data |
| st_wr_en | input | 1 | Status write strobe |
| st_wr_data | input | 16 | New status word from the arithmetic unit |
| st_data | output | 16 | Current status register |
| shadow_save | input | 1 | Copy registers 0 to 3 and saved flags into the shadow store |
| shadow_restore | input | 1 | Copy the shadow store back |

## Verification
The bench checks that a byte write leaves the high byte alone. A design that merged the wrong byte would corrupt the upper half. It checks that a restore puts back only the five saved flags, so a full-word restore would wipe the priority and loop-active bits. It checks that writes after a save do not leak into the shadow store, and that a second save replaces the first. Two same-cycle collisions are covered. A restore must beat a port write to registers 0 to 3, and a save plus a restore must swap contents rather than lose one side. A mid-run reset must restore 0x0800 in the stack pointer and clear the shadow store.

// File: rtl/regfile_pkg.sv
package regfile_pkg;

    localparam int unsigned NREG     = 16;
    localparam int unsigned DW       = 16;
    localparam int unsigned AW       = $clog2(NREG);
    localparam int unsigned NSHADOW  = 4;
    localparam int unsigned SP_INDEX = NREG - 1;
    localparam logic [DW-1:0] SP_RESET = 16'h0800;

    // status bit positions
    localparam int unsigned ST_CARRY  = 0;
    localparam int unsigned ST_ZERO   = 1;
    localparam int unsigned ST_OVFL   = 2;
    localparam int unsigned ST_NEG    = 3;
    localparam int unsigned ST_RPT    = 4;
    localparam int unsigned ST_PRI_LO = 5;
    localparam int unsigned ST_DCARRY = 8;
    localparam int unsigned ST_LOOP   = 9;

    localparam logic [DW-1:0] SHADOW_FLAG_MASK =
        (DW'(1) << ST_CARRY) | (DW'(1) << ST_ZERO) | (DW'(1) << ST_OVFL) |
        (DW'(1) << ST_NEG)   | (DW'(1) << ST_DCARRY);

    typedef enum logic {
        WSIZE_WORD = 1'b0,
        WSIZE_BYTE = 1'b1
    } wsize_e;

    typedef struct packed {
        logic          en;
        logic [AW-1:0] addr;
        wsize_e        size;
        logic [DW-1:0] data;
    } wreq_t;

    function automatic logic [DW-1:0] merge_write(
        input logic [DW-1:0] old_v,
        input logic [DW-1:0] new_v,
        input wsize_e        size
    );
        if (size == WSIZE_BYTE)
            return {old_v[DW-1:8], new_v[7:0]};
        return new_v;
    endfunction

endpackage

// File: rtl/rf_wreg_array.sv
module rf_wreg_array
    import regfile_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  wreq_t                 wreq,
    input  logic                  restore,
    input  logic [NSHADOW*DW-1:0] restore_flat,
    output logic [NREG*DW-1:0]    w_flat
);

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        localparam logic [DW-1:0] RST_VAL = (i == SP_INDEX) ? SP_RESET : '0;
        logic [DW-1:0] q;
        logic [DW-1:0] d;
        logic          hit;

        assign hit = wreq.en && (wreq.addr == AW'(i));

        if (i < NSHADOW) begin : g_shadowed
            always_comb begin
                if (restore)
                    d = restore_flat[i*DW +: DW];
                else if (hit)
                    d = merge_write(q, wreq.data, wreq.size);
                else
                    d = q;
            end
        end else begin : g_plain
            always_comb begin
                d = hit ? merge_write(q, wreq.data, wreq.size) : q;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) q <= RST_VAL;
            else     q <= d;
        end

        assign w_flat[i*DW +: DW] = q;
    end

endmodule

// File: rtl/rf_status.sv
module rf_status
    import regfile_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          restore,
    input  logic [DW-1:0] restore_flags,
    output logic [DW-1:0] st_q
);

    logic [DW-1:0] base;
    logic [DW-1:0] st_d;

    always_comb begin
        base = wr_en ? wr_data : st_q;
        if (restore)
            st_d = (base & ~SHADOW_FLAG_MASK) | (restore_flags & SHADOW_FLAG_MASK);
        else
            st_d = base;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

endmodule

// File: rtl/rf_shadow.sv
module rf_shadow
    import regfile_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  save,
    input  logic [NSHADOW*DW-1:0] live_w,
    input  logic [DW-1:0]         live_st,
    output logic [NSHADOW*DW-1:0] sh_w,
    output logic [DW-1:0]         sh_st
);

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_w  <= '0;
            sh_st <= '0;
        end else if (save) begin
            sh_w  <= live_w;
            sh_st <= live_st & SHADOW_FLAG_MASK;
        end
    end

endmodule

// File: rtl/rf_core.sv
module rf_core
    import regfile_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [3:0]    rd_addr_a,
    output logic [15:0]   rd_data_a,
    input  logic [3:0]    rd_addr_b,
    output logic [15:0]   rd_data_b,
    input  logic          wr_en,
    input  logic [3:0]    wr_addr,
    input  logic          wr_byte,
    input  logic [15:0]   wr_data,
    input  logic          st_wr_en,
    input  logic [15:0]   st_wr_data,
    output logic [15:0]   st_data,
    input  logic          shadow_save,
    input  logic          shadow_restore
);

    wreq_t                 wreq;
    logic [NREG*DW-1:0]    w_flat;
    logic [NSHADOW*DW-1:0] sh_w;
    logic [DW-1:0]         sh_st;
    logic [DW-1:0]         st_q;

    always_comb begin
        wreq.en   = wr_en;
        wreq.addr = wr_addr;
        wreq.size = wr_byte ? WSIZE_BYTE : WSIZE_WORD;
        wreq.data = wr_data;
    end

    rf_wreg_array u_array (
        .clk          (clk),
        .rst          (rst),
        .wreq         (wreq),
        .restore      (shadow_restore),
        .restore_flat (sh_w),
        .w_flat       (w_flat)
    );

    rf_status u_status (
        .clk           (clk),
        .rst           (rst),
        .wr_en         (st_wr_en),
        .wr_data       (st_wr_data),
        .restore       (shadow_restore),
        .restore_flags (sh_st),
        .st_q          (st_q)
    );

    rf_shadow u_shadow (
        .clk     (clk),
        .rst     (rst),
        .save    (shadow_save),
        .live_w  (w_flat[NSHADOW*DW-1:0]),
        .live_st (st_q),
        .sh_w    (sh_w),
        .sh_st   (sh_st)
    );

    assign rd_data_a = w_flat[rd_addr_a*DW +: DW];
    assign rd_data_b = w_flat[rd_addr_b*DW +: DW];
    assign st_data   = st_q;

endmodule

// File: rtl/rf_core_chk.sv
module rf_core_chk
    import regfile_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  wr_en,
    input logic [AW-1:0]         wr_addr,
    input logic                  wr_byte,
    input logic                  st_wr_en,
    input logic                  shadow_save,
    input logic                  shadow_restore,
    input logic [NREG*DW-1:0]    w_flat,
    input logic [NSHADOW*DW-1:0] sh_w,
    input logic [DW-1:0]         sh_st,
    input logic [DW-1:0]         st_q
);

    // R4: stack pointer holds its reset value in the first cycle after reset
    a_r4_sp_reset: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> w_flat[SP_INDEX*DW +: DW] == SP_RESET);

    // R6: save captures live registers 0-3 and the flag subset
    a_r6_save_capture: assert property (@(posedge clk) disable iff (rst)
        shadow_save |=> (sh_w == $past(w_flat[NSHADOW*DW-1:0])) &&
                        (sh_st == ($past(st_q) & SHADOW_FLAG_MASK)));

    // R8: shadow store only moves on a save
    a_r8_shadow_hold: assert property (@(posedge clk) disable iff (rst)
        !shadow_save |=> $stable(sh_w) && $stable(sh_st));

    // R3: byte write keeps the upper byte
    a_r3_byte_keeps_high: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_byte && !(shadow_restore && (32'(wr_addr) < NSHADOW))) |=>
        w_flat[$past(wr_addr)*DW + 8 +: 8] == $past(w_flat[wr_addr*DW + 8 +: 8]));

    // R7 / R9: restore overrides registers 0-3
    a_r9_restore_wins: assert property (@(posedge clk) disable iff (rst)
        shadow_restore |=> w_flat[NSHADOW*DW-1:0] == $past(sh_w));

    // R7: unsaved status bits untouched by a restore without a status write
    a_r7_unsaved_bits_kept: assert property (@(posedge clk) disable iff (rst)
        (shadow_restore && !st_wr_en) |=>
        (st_q & ~SHADOW_FLAG_MASK) == ($past(st_q) & ~SHADOW_FLAG_MASK));

endmodule

bind rf_core rf_core_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .wr_en          (wr_en),
    .wr_addr        (wr_addr),
    .wr_byte        (wr_byte),
    .st_wr_en       (st_wr_en),
    .shadow_save    (shadow_save),
    .shadow_restore (shadow_restore),
    .w_flat         (w_flat),
    .sh_w           (sh_w),
    .sh_st          (sh_st),
    .st_q           (st_q)
);

// File: tb/rf_core_bench.sv
module rf_core_bench;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic        we;
        logic        byt;
        logic [3:0]  addr;
        logic [15:0] data;
        logic [15:0] expv;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 1'b0, 4'd1,  16'h1234, 16'h1234},  // R2
        '{1'b1, 1'b0, 4'd15, 16'hBEEF, 16'hBEEF},  // R4 sp writable
        '{1'b1, 1'b1, 4'd1,  16'hFFAB, 16'h12AB},  // R3
        '{1'b1, 1'b0, 4'd7,  16'hA5A5, 16'hA5A5},  // R2
        '{1'b0, 1'b0, 4'd7,  16'h0000, 16'hA5A5},  // R1 no write
        '{1'b1, 1'b1, 4'd7,  16'h0011, 16'hA511},  // R3
        '{1'b1, 1'b0, 4'd0,  16'h0F0F, 16'h0F0F},  // R2
        '{1'b1, 1'b1, 4'd15, 16'h0000, 16'hBE00}   // R3
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  rd_addr_a = '0, rd_addr_b = '0, wr_addr = '0;
    logic [15:0] rd_data_a, rd_data_b, wr_data = '0, st_wr_data = '0, st_data;
    logic        wr_en = 1'b0, wr_byte = 1'b0, st_wr_en = 1'b0;
    logic        shadow_save = 1'b0, shadow_restore = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rf_core u_rf_core (
        .clk(clk), .rst(rst),
        .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
        .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_byte(wr_byte), .wr_data(wr_data),
        .st_wr_en(st_wr_en), .st_wr_data(st_wr_data), .st_data(st_data),
        .shadow_save(shadow_save), .shadow_restore(shadow_restore)
    );

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] expv);
        checks++;
        if (got !== expv) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, expv);
        end
    endtask

    task automatic read_check(input string req, input logic [3:0] a, input logic [15:0] expv);
        rd_addr_a = a;
        rd_addr_b = a;
        #1;
        check(req, rd_data_a, expv);
        check(req, rd_data_b, expv);
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d, input logic byt);
        wr_en = 1'b1; wr_addr = a; wr_data = d; wr_byte = byt;
        cyc();
        wr_en = 1'b0; wr_byte = 1'b0;
    endtask

    task automatic stw(input logic [15:0] d);
        st_wr_en = 1'b1; st_wr_data = d;
        cyc();
        st_wr_en = 1'b0;
    endtask

    task automatic save();
        shadow_save = 1'b1; cyc(); shadow_save = 1'b0;
    endtask

    task automatic restore();
        shadow_restore = 1'b1; cyc(); shadow_restore = 1'b0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        cyc(); cyc();
        rst = 1'b0;
        #1;
        // R4 reset state
        read_check("R4", 4'd15, 16'h0800);
        read_check("R4", 4'd3, 16'h0000);
        check("R4", st_data, 16'h0000);

        // R1 R2 R3 table walk
        for (int i = 0; i < NVEC; i++) begin
            wr_en = VECS[i].we; wr_byte = VECS[i].byt;
            wr_addr = VECS[i].addr; wr_data = VECS[i].data;
            cyc();
            wr_en = 1'b0; wr_byte = 1'b0;
            read_check("R1/R2/R3 table", VECS[i].addr, VECS[i].expv);
        end

        // R5 status write
        stw(16'h1234);
        check("R5", st_data, 16'h1234);

        // R6 R7 R8 save, clobber, restore
        wr(4'd0, 16'h1111, 1'b0);
        wr(4'd1, 16'h2222, 1'b0);
        wr(4'd2, 16'h3333, 1'b0);
        wr(4'd3, 16'h4444, 1'b0);
        stw(16'hFFFF);
        save();
        for (int i = 0; i < 4; i++) wr(4'(i), 16'h0000, 1'b0);
        stw(16'h0000);
        read_check("R8 shadow hidden", 4'd0, 16'h0000);
        restore();
        read_check("R6", 4'd0, 16'h1111);
        read_check("R6", 4'd1, 16'h2222);
        read_check("R6", 4'd2, 16'h3333);
        read_check("R6", 4'd3, 16'h4444);
        check("R7 flags only", st_data, 16'h010F);

        // R10 second save overwrites
        save();
        wr(4'd1, 16'hAAAA, 1'b0);
        save();
        wr(4'd1, 16'hBBBB, 1'b0);
        restore();
        read_check("R10", 4'd1, 16'hAAAA);
        read_check("R10", 4'd0, 16'h1111);

        // R9 restore beats write; R7 combined status write
        shadow_restore = 1'b1;
        wr_en = 1'b1; wr_addr = 4'd2; wr_data = 16'hDEAD;
        st_wr_en = 1'b1; st_wr_data = 16'h02F0;
        cyc();
        shadow_restore = 1'b0; wr_en = 1'b0; st_wr_en = 1'b0;
        read_check("R9", 4'd2, 16'h3333);
        check("R7 with status write", st_data, 16'h03FF);

        shadow_restore = 1'b1;
        wr_en = 1'b1; wr_addr = 4'd5; wr_data = 16'h5555;
        cyc();
        shadow_restore = 1'b0; wr_en = 1'b0;
        read_check("R9 upper reg", 4'd5, 16'h5555);

        // R11 save + restore exchange
        wr(4'd0, 16'h0C0C, 1'b0);
        shadow_save = 1'b1; shadow_restore = 1'b1;
        cyc();
        shadow_save = 1'b0; shadow_restore = 1'b0;
        read_check("R11", 4'd0, 16'h1111);
        restore();
        read_check("R11", 4'd0, 16'h0C0C);

        // R4 mid-run reset
        rst = 1'b1;
        cyc();
        rst = 1'b0;
        #1;
        read_check("R4 rerun", 4'd15, 16'h0800);
        read_check("R4 rerun", 4'd5, 16'h0000);
        check("R4 rerun", st_data, 16'h0000);
        restore();
        read_check("R4 shadow cleared", 4'd0, 16'h0000);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule